// File: doc/BRIEF.md
# Latched Position Bus Port

This block sits between a position tracking counter and a host data bus. It keeps a snapshot register of the counter's 16-bit word. The host can freeze that snapshot for a multi-byte read. The block also controls a shared set of sixteen data pins: it sets their drive, their direction and which byte appears on them.

A host with an 8-bit bus reads the eight upper pins twice, once with each setting of the byte select. A host with a 16-bit bus reads all sixteen pins at once. The same pins can be turned around to carry a preset word back to the counter. A complement control can invert the word before it is presented on the pins.

The pins are modelled as three separate vectors: an output value, a per-bit output enable and an input value. Pin vector bit 15 is the most significant pin of the bus and bit 0 is the least significant.

Top module: `pos_bus_port`

## Requirements
- R1: While reset is asserted, and until the first capture after it, the snapshot is zero and `preset_en` is 0.
- R2: At a clock edge where `hold_n` is 1 and `cnt_busy` is 0, the snapshot takes the value of `cnt_pos`, and the pins show it after that edge.
- R3: At an edge where `hold_n` is 0, the snapshot keeps its value. With the steering controls held, the pin value stays constant while the counter keeps moving.
- R4: At an edge where `cnt_busy` is 1, the snapshot keeps its value even when `hold_n` is 1.
- R5: When `bus_en_n` is 1, all sixteen bits of `pin_oe` are 0. When `bus_en_n` is 0 and `dir_in_n` is 1, all sixteen bits are 1.
- R6: `pin_o[7:0]` always carries the low byte of the presented word. `pin_o[15:8]` carries the high byte when `hi_sel` is 1 and the low byte when `hi_sel` is 0.
- R7: When `inv_n` is 0, the presented word is the bitwise inverse of the snapshot. When `inv_n` is 1, the presented word is the snapshot itself.
- R8: When `dir_in_n` is 0, `pin_oe` is all zeros whatever `bus_en_n` is. After the next edge, `preset_en` is 1 and `preset_val` holds `pin_i` as sampled at that edge.
- R9: After an edge where `dir_in_n` is 1, `preset_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_pos | input | 16 | Live counter position |
| cnt_busy | input | 1 | High while the counter word is changing |
| hold_n | input | 1 | Low freezes the snapshot |
| bus_en_n | input | 1 | Low enables pin drive |
| hi_sel | input | 1 | High steers the high byte onto the upper pins |
| inv_n | input | 1 | Low inverts the presented word |
| dir_in_n | input | 1 | Low turns the pins into inputs for presetting the counter |
| pin_i | input | 16 | Values read from the data pins |
| pin_o | output | 16 | Values driven onto the data pins |
| pin_oe | output | 16 | Per-pin output enable |
| preset_en | output | 1 | Registered strobe: load `preset_val` into the counter |
| preset_val | output | 16 | Registered preset word taken from the pins |

## Verification
The assertions check on every cycle that the snapshot either holds or captures according to `hold_n` and `cnt_busy`. They also check that pin drive is off whenever the block is disabled or the pins are turned to input, that the low pin lane follows the snapshot through the inversion control, and that the preset register follows the pins one cycle later.

Some behaviour can only be shown by the bench's scenarios. One is that a value read during a long freeze stays constant while the counter keeps stepping. Another is the byte steering seen by an 8-bit host. A third is the combined effect of random inversion, steering and turnaround, measured against an independent model.

// File: rtl/pos_bus_pkg.sv
package pos_bus_pkg;
  localparam int POS_W  = 16;
  localparam int LANE_W = 8;
endpackage

// File: rtl/pos_rst_sync.sv
module pos_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pos_snap_latch.sv
module pos_snap_latch #(
  parameter int W = pos_bus_pkg::POS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_pos,
  input  logic         cnt_busy,
  input  logic         hold_n,
  output logic [W-1:0] snap
);
  logic         cap_en;
  logic [W-1:0] snap_d, snap_q;

  // Capture only when the host allows it and the counter word is settled.
  always_comb begin
    cap_en = hold_n & ~cnt_busy;
    snap_d = cap_en ? cnt_pos : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign snap = snap_q;
endmodule

// File: rtl/pos_byte_steer.sv
module pos_byte_steer #(
  parameter int W      = pos_bus_pkg::POS_W,
  parameter int LANE_W = pos_bus_pkg::LANE_W
) (
  input  logic [W-1:0] snap,
  input  logic         hi_sel,
  input  logic         inv_n,
  output logic [W-1:0] pin_o
);
  localparam int NLANE = W / LANE_W;
  localparam int TOP   = NLANE - 1;

  logic [W-1:0] word;

  assign word = inv_n ? snap : ~snap;

  // The top lane is shared by both bytes; the other lanes pass straight through.
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    if (l == TOP) begin : g_shared
      assign pin_o[l*LANE_W +: LANE_W] =
        hi_sel ? word[TOP*LANE_W +: LANE_W] : word[0 +: LANE_W];
    end else begin : g_direct
      assign pin_o[l*LANE_W +: LANE_W] = word[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/pos_bus_dir.sv
module pos_bus_dir #(
  parameter int W = pos_bus_pkg::POS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_en_n,
  input  logic         dir_in_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_oe,
  output logic         preset_en,
  output logic [W-1:0] preset_val
);
  logic         pe_d, pe_q;
  logic [W-1:0] pv_d, pv_q;

  always_comb begin
    pe_d = ~dir_in_n;
    pv_d = dir_in_n ? pv_q : pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q <= 1'b0;
      pv_q <= '0;
    end else begin
      pe_q <= pe_d;
      pv_q <= pv_d;
    end
  end

  // Drive is forced off while the pins act as inputs.
  assign pin_oe     = {W{~bus_en_n & dir_in_n}};
  assign preset_en  = pe_q;
  assign preset_val = pv_q;
endmodule

// File: rtl/pos_bus_port.sv
module pos_bus_port #(
  parameter int W      = pos_bus_pkg::POS_W,
  parameter int LANE_W = pos_bus_pkg::LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_pos,
  input  logic         cnt_busy,
  input  logic         hold_n,
  input  logic         bus_en_n,
  input  logic         hi_sel,
  input  logic         inv_n,
  input  logic         dir_in_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic         preset_en,
  output logic [W-1:0] preset_val
);
  logic         rst_sync_n;
  logic [W-1:0] snap;

  pos_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pos_snap_latch #(.W(W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cnt_pos  (cnt_pos),
    .cnt_busy (cnt_busy),
    .hold_n   (hold_n),
    .snap     (snap)
  );

  pos_byte_steer #(.W(W), .LANE_W(LANE_W)) u_steer (
    .snap   (snap),
    .hi_sel (hi_sel),
    .inv_n  (inv_n),
    .pin_o  (pin_o)
  );

  pos_bus_dir #(.W(W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_en_n   (bus_en_n),
    .dir_in_n   (dir_in_n),
    .pin_i      (pin_i),
    .pin_oe     (pin_oe),
    .preset_en  (preset_en),
    .preset_val (preset_val)
  );
endmodule

// File: rtl/pos_bus_port_chk.sv
module pos_bus_port_chk #(
  parameter int W      = pos_bus_pkg::POS_W,
  parameter int LANE_W = pos_bus_pkg::LANE_W
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic [W-1:0] snap,
  input logic [W-1:0] cnt_pos,
  input logic         cnt_busy,
  input logic         hold_n,
  input logic         bus_en_n,
  input logic         inv_n,
  input logic         dir_in_n,
  input logic [W-1:0] pin_i,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oe,
  input logic         preset_en,
  input logic [W-1:0] preset_val
);
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hold_n && !cnt_busy) |=> (snap == $past(cnt_pos))); // R2
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hold_n |=> $stable(snap)); // R3
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_busy |=> $stable(snap)); // R4
  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_en_n || !dir_in_n) |-> (pin_oe == '0)); // R5
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_en_n && dir_in_n) |-> (pin_oe == '1)); // R5
  AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin_o[LANE_W-1:0] == (inv_n ? snap[LANE_W-1:0] : ~snap[LANE_W-1:0])); // R7
  AST_PRESET_TAKE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dir_in_n |=> (preset_en && preset_val == $past(pin_i))); // R8
  AST_PRESET_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dir_in_n |=> !preset_en); // R9
endmodule

bind pos_bus_port pos_bus_port_chk #(.W(W), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .snap       (snap),
  .cnt_pos    (cnt_pos),
  .cnt_busy   (cnt_busy),
  .hold_n     (hold_n),
  .bus_en_n   (bus_en_n),
  .inv_n      (inv_n),
  .dir_in_n   (dir_in_n),
  .pin_i      (pin_i),
  .pin_o      (pin_o),
  .pin_oe     (pin_oe),
  .preset_en  (preset_en),
  .preset_val (preset_val)
);

// File: tb/pos_bus_port_bench.sv
module pos_bus_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_pos = '0;
  logic        cnt_busy = 1'b0;
  logic        hold_n = 1'b0;
  logic        bus_en_n = 1'b1;
  logic        hi_sel = 1'b0;
  logic        inv_n = 1'b1;
  logic        dir_in_n = 1'b1;
  logic [15:0] pin_i = '0;
  logic [15:0] pin_o, pin_oe, preset_val;
  logic        preset_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_snap = '0;
  logic        m_pe = 1'b0;
  logic [15:0] m_pv = '0;

  always #5 clk = ~clk;

  pos_bus_port u_pos_bus_port (
    .clk(clk), .rst_n(rst_n), .cnt_pos(cnt_pos), .cnt_busy(cnt_busy),
    .hold_n(hold_n), .bus_en_n(bus_en_n), .hi_sel(hi_sel), .inv_n(inv_n),
    .dir_in_n(dir_in_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .preset_en(preset_en), .preset_val(preset_val)
  );

  function automatic logic [15:0] exp_pins(input logic [15:0] s, input logic hs, input logic iv);
    logic [15:0] w;
    w = iv ? s : ~s;
    return {hs ? w[15:8] : w[7:0], w[7:0]};
  endfunction

  function automatic logic [15:0] exp_oe(input logic en_n, input logic dn);
    return (!en_n && dn) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Clock edge, model update, then sampling away from the edge.
  task automatic step();
    @(posedge clk);
    if (hold_n && !cnt_busy) m_snap = cnt_pos;
    m_pe = !dir_in_n;
    if (!dir_in_n) m_pv = pin_i;
    #2;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R6/R7 pins"}, {16'h0, pin_o}, {16'h0, exp_pins(m_snap, hi_sel, inv_n)});
    chk({tag, " R5/R8 oe"}, {16'h0, pin_oe}, {16'h0, exp_oe(bus_en_n, dir_in_n)});
    chk({tag, " R8/R9 preset_en"}, {31'h0, preset_en}, {31'h0, m_pe});
    chk({tag, " R8 preset_val"}, {16'h0, preset_val}, {16'h0, m_pv});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] frozen;
    void'($urandom(32'd20241));
    // R1: reset state
    bus_en_n = 1'b0;
    cnt_pos = 16'hA5C3;
    hold_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 snapshot zero in reset", {16'h0, pin_o}, 32'h0);
    chk("R1 preset_en low in reset", {31'h0, preset_en}, 32'h0);
    @(negedge clk);
    hold_n = 1'b0;
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 snapshot still zero after release", {16'h0, pin_o}, 32'h0);

    // R2: directed capture, with both byte selections
    @(negedge clk);
    hold_n = 1'b1; cnt_pos = 16'h12F4; hi_sel = 1'b1;
    step();
    chk("R2 capture high byte", {16'h0, pin_o}, {16'h0, 16'h12F4});
    @(negedge clk); hi_sel = 1'b0; #1;
    chk("R6 low byte on upper pins", {16'h0, pin_o}, {16'h0, 16'hF4F4});

    // R3: freeze while the counter steps
    @(negedge clk); hold_n = 1'b0; hi_sel = 1'b1;
    step();
    frozen = pin_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); cnt_pos = cnt_pos + 16'd37;
      step();
      if (i % 5 == 4) chk("R3 frozen read constant", {16'h0, pin_o}, {16'h0, frozen});
    end

    // R4: busy blocks capture
    @(negedge clk); hold_n = 1'b1; cnt_busy = 1'b1; cnt_pos = 16'hBEEF;
    step();
    chk("R4 busy holds snapshot", {16'h0, pin_o}, {16'h0, frozen});
    @(negedge clk); cnt_busy = 1'b0;
    step();
    chk("R4 capture after busy clears", {16'h0, pin_o}, {16'h0, 16'hBEEF});

    // R7: inversion
    @(negedge clk); inv_n = 1'b0; #1;
    chk("R7 inverted word", {16'h0, pin_o}, {16'h0, 16'h4110});
    @(negedge clk); inv_n = 1'b1;

    // R5: drive disabled
    @(negedge clk); bus_en_n = 1'b1; #1;
    chk("R5 pins released", {16'h0, pin_oe}, 32'h0);

    // R8: turnaround with enable asserted
    @(negedge clk); bus_en_n = 1'b0; dir_in_n = 1'b0; pin_i = 16'h5A3C; #1;
    chk("R8 drive off on input", {16'h0, pin_oe}, 32'h0);
    step();
    chk("R8 preset strobe", {31'h0, preset_en}, 32'h1);
    chk("R8 preset value", {16'h0, preset_val}, {16'h0, 16'h5A3C});
    @(negedge clk); dir_in_n = 1'b1;
    step();
    chk("R9 strobe drops", {31'h0, preset_en}, 32'h0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cnt_pos  = 16'($urandom);
      cnt_busy = ($urandom % 4) == 0;
      hold_n   = ($urandom % 3) != 0;
      bus_en_n = ($urandom % 4) == 0;
      hi_sel   = 1'($urandom);
      inv_n    = ($urandom % 4) != 0;
      dir_in_n = ($urandom % 5) != 0;
      pin_i    = 16'($urandom);
      step();
      check_all("random R2/R3/R4");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule